// File: doc/BRIEF.md
# PS/2 Keyboard Scan Decoder

This block listens to the two open-collector lines of a PS/2 keyboard and turns the serial traffic into key events. Both lines are first brought into the system clock domain. A falling edge of the keyboard clock only counts once the synchronised level has held for a set number of system clocks, so short glitches are filtered out. On each accepted falling edge the block samples one bit of the 11-bit frame. A frame carries these bits in order: a low start bit, eight data bits with the least significant bit first, an odd parity bit, and a high stop bit.

Each good byte is handled as follows. The byte 0xF0 arms a pending release. The byte 0xE0 arms a pending extended flag. Any other byte completes a key. For a completed key the block raises a one-cycle event that carries the scan code together with the pending release and extended flags, and then clears both pending flags. A frame that fails its checks produces a one-cycle error pulse and no event, and it drops any pending prefix. If the clock stops partway through a frame for longer than a timeout, the bit counter returns to idle. The block only receives: it never drives the bus.

Top module: `ps2_key_decoder`

## Requirements
- R1: After reset, key_valid, key_release, key_extended and frame_err are all low.
- R2: A good frame whose byte is neither 0xF0 nor 0xE0 gives exactly one key_valid pulse of one cycle. The pulse has key_code equal to the byte and key_release = key_extended = 0 when no prefix is pending.
- R3: A good 0xF0 frame followed by a good code frame gives one event with key_release = 1 and key_extended = 0.
- R4: A good 0xE0 frame followed by a code gives key_extended = 1. The sequence 0xE0, 0xF0, code gives key_extended = 1 and key_release = 1.
- R5: Prefix frames (0xF0, 0xE0) produce no key_valid pulse. Their flags apply to the next event only and are then cleared.
- R6: Each repeated make frame of a held key produces its own press event.
- R7: A frame whose parity bit makes the count of ones over data and parity even gives one frame_err pulse and no event.
- R8: A frame with a high start bit, or with a low stop bit, gives one frame_err pulse and no event.
- R9: A bad frame clears any pending release or extended prefix.
- R10: If no accepted clock edge arrives for TIMEOUT_CYC system clocks while a frame is partly received, the partial frame is dropped. The next complete frame is then decoded correctly.
- R11: A low pulse on the keyboard clock that is shorter than FILT_LEN system clocks is not taken as an edge.
- R12: Data bits are taken least significant bit first, so every one of the 254 non-prefix byte values comes out unchanged on key_code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ps2_clk | input | 1 | Keyboard clock line (asynchronous) |
| ps2_dat | input | 1 | Keyboard data line (asynchronous) |
| key_valid | output | 1 | One-cycle key event strobe |
| key_code | output | 8 | Scan code of the last event |
| key_release | output | 1 | Event is a key release (valid with key_valid) |
| key_extended | output | 1 | Event is an extended key (valid with key_valid) |
| frame_err | output | 1 | One-cycle pulse on a rejected frame |

## Verification
The assertions assume that the keyboard clock holds each phase for much longer than the filter length plus the synchroniser delay. They also assume that consecutive frames are separated by many system clocks, so two strobes can never fall on adjacent cycles. The stimulus keeps each clock phase at 12 system clocks against a 4-clock filter. It changes data only in the middle of a high phase and leaves an idle gap after every frame. The only deliberately short clock pulses are the glitches used to check the filter.

// File: rtl/ps2_key_decoder.sv
module ps2_key_decoder #(
  parameter int FILT_LEN    = 8,
  parameter int TIMEOUT_CYC = 100000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ps2_clk,
  input  logic       ps2_dat,
  output logic       key_valid,
  output logic [7:0] key_code,
  output logic       key_release,
  output logic       key_extended,
  output logic       frame_err
);
  localparam int FW = $clog2(FILT_LEN + 1);
  localparam int TW = $clog2(TIMEOUT_CYC + 1);
  localparam logic [FW-1:0] FMAX = FW'(FILT_LEN - 1);
  localparam logic [TW-1:0] TMAX = TW'(TIMEOUT_CYC - 1);
  localparam logic [7:0] BRK = 8'hF0;
  localparam logic [7:0] EXT = 8'hE0;

  logic [1:0]    clk_sy, dat_sy;
  logic          clk_f;
  logic [FW-1:0] fcnt;
  logic [3:0]    bitcnt;
  logic [TW-1:0] tmo;
  logic [9:0]    sh;
  logic          brk_pend, ext_pend;

  logic fall, done, good;
  logic [7:0] byte_in;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      clk_sy <= 2'b11;
      dat_sy <= 2'b11;
    end else begin
      clk_sy <= {clk_sy[0], ps2_clk};
      dat_sy <= {dat_sy[0], ps2_dat};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      clk_f <= 1'b1;
      fcnt  <= '0;
    end else if (clk_sy[1] == clk_f) begin
      fcnt <= '0;
    end else if (fcnt == FMAX) begin
      clk_f <= clk_sy[1];
      fcnt  <= '0;
    end else begin
      fcnt <= fcnt + 1'b1;
    end
  end

  assign fall    = clk_f & ~clk_sy[1] & (fcnt == FMAX);
  assign done    = fall & (bitcnt == 4'd10);
  assign byte_in = sh[8:1];
  assign good    = ~sh[0] & dat_sy[1] & (^sh[9:1]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bitcnt <= '0;
      tmo    <= '0;
      sh     <= '0;
    end else if (fall) begin
      tmo    <= '0;
      sh     <= {dat_sy[1], sh[9:1]};
      bitcnt <= done ? 4'd0 : bitcnt + 4'd1;
    end else if (bitcnt != 4'd0) begin
      if (tmo == TMAX) begin
        tmo    <= '0;
        bitcnt <= '0;
      end else begin
        tmo <= tmo + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      key_valid    <= 1'b0;
      key_code     <= '0;
      key_release  <= 1'b0;
      key_extended <= 1'b0;
      frame_err    <= 1'b0;
      brk_pend     <= 1'b0;
      ext_pend     <= 1'b0;
    end else begin
      key_valid    <= 1'b0;
      key_release  <= 1'b0;
      key_extended <= 1'b0;
      frame_err    <= 1'b0;
      if (done) begin
        if (!good) begin
          frame_err <= 1'b1;
          brk_pend  <= 1'b0;
          ext_pend  <= 1'b0;
        end else if (byte_in == BRK) begin
          brk_pend <= 1'b1;
        end else if (byte_in == EXT) begin
          ext_pend <= 1'b1;
        end else begin
          key_valid    <= 1'b1;
          key_code     <= byte_in;
          key_release  <= brk_pend;
          key_extended <= ext_pend;
          brk_pend     <= 1'b0;
          ext_pend     <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/ps2_key_decoder_chk.sv
module ps2_key_decoder_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       key_valid,
  input logic [7:0] key_code,
  input logic       key_release,
  input logic       key_extended,
  input logic       frame_err
);
  a_r2_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    key_valid |=> !key_valid);

  a_r5_no_prefix_code: assert property (@(posedge clk) disable iff (!rst_n)
    key_valid |-> (key_code != 8'hF0 && key_code != 8'hE0));

  a_r3_flags_with_event: assert property (@(posedge clk) disable iff (!rst_n)
    (key_release || key_extended) |-> key_valid);

  a_r7_err_no_event: assert property (@(posedge clk) disable iff (!rst_n)
    frame_err |-> !key_valid);

  a_r8_err_single: assert property (@(posedge clk) disable iff (!rst_n)
    frame_err |=> !frame_err);
endmodule

bind ps2_key_decoder ps2_key_decoder_chk u_chk (
  .clk(clk), .rst_n(rst_n), .key_valid(key_valid), .key_code(key_code),
  .key_release(key_release), .key_extended(key_extended), .frame_err(frame_err)
);

// File: tb/tb_ps2_key_decoder.sv
module tb_ps2_key_decoder;
  localparam int FILT = 4;
  localparam int TMO  = 150;
  localparam int HALF = 12;
  localparam int GAP  = 30;

  logic clk = 1'b0, rst_n = 1'b0, pclk = 1'b1, pdat = 1'b1;
  logic kv, kr, ke, fe;
  logic [7:0] kc;
  int n_chk = 0, n_bad = 0, ev_cnt = 0, er_cnt = 0, cyc = 0;
  logic [7:0] last_code = '0;
  logic last_rel = 1'b0, last_ext = 1'b0;
  bit done_flag = 1'b0;

  always #4 clk = ~clk;

  ps2_key_decoder #(.FILT_LEN(FILT), .TIMEOUT_CYC(TMO)) dut (
    .clk(clk), .rst_n(rst_n), .ps2_clk(pclk), .ps2_dat(pdat),
    .key_valid(kv), .key_code(kc), .key_release(kr), .key_extended(ke),
    .frame_err(fe));

  always @(negedge clk) begin
    if (kv) begin
      ev_cnt    <= ev_cnt + 1;
      last_code <= kc;
      last_rel  <= kr;
      last_ext  <= ke;
    end
    if (fe) er_cnt <= er_cnt + 1;
  end

  task automatic summary();
    if (!done_flag) begin
      done_flag = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 190000) begin
      n_chk = n_chk + 1;
      n_bad = n_bad + 1;
      $display("FAIL watchdog: run hung, actual %0d cycles expected < 190000", cyc);
      summary();
    end
  end

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input int act, input int exp);
    n_chk = n_chk + 1;
    if (act != exp) begin
      n_bad = n_bad + 1;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // nbits: number of bits to send (11 = full frame); glitch inserts short low pulse
  task automatic send(input logic [7:0] b, input bit bad_par, input bit bad_start,
                      input bit bad_stop, input int nbits, input bit glitch);
    logic [10:0] w;
    w = {~bad_stop, (~^b) ^ bad_par, b, bad_start};
    for (int i = 0; i < nbits; i++) begin
      wait_cyc(HALF / 2);
      pdat = w[i];
      if (glitch && i == 4) begin
        pclk = 1'b0; wait_cyc(FILT - 2); pclk = 1'b1;
        wait_cyc(HALF / 2 - FILT + 2);
      end else begin
        wait_cyc(HALF / 2);
      end
      pclk = 1'b0;
      wait_cyc(HALF);
      pclk = 1'b1;
    end
    wait_cyc(HALF / 2);
    pdat = 1'b1;
    wait_cyc(GAP);
  endtask

  task automatic good(input logic [7:0] b);
    send(b, 1'b0, 1'b0, 1'b0, 11, 1'b0);
  endtask

  task automatic expect_ev(input string req, input int e0, input int r0,
                           input logic [7:0] code, input bit rel, input bit ext);
    check(req, ev_cnt - e0, 1);
    check(req, {last_code, last_rel, last_ext}, {code, rel, ext});
    check(req, er_cnt - r0, 0);
  endtask

  initial begin
    int e0, r0;
    wait_cyc(3);
    check("R1", {kv, kr, ke, fe}, 0);
    rst_n = 1'b1;
    wait_cyc(5);
    check("R1", {kv, kr, ke, fe}, 0);

    // R2 plain make
    e0 = ev_cnt; r0 = er_cnt;
    good(8'h1C);
    expect_ev("R2", e0, r0, 8'h1C, 1'b0, 1'b0);

    // R3 release
    e0 = ev_cnt; r0 = er_cnt;
    good(8'hF0);
    check("R5", ev_cnt - e0, 0);
    good(8'h1C);
    expect_ev("R3", e0, r0, 8'h1C, 1'b1, 1'b0);

    // R4 extended make and release
    e0 = ev_cnt; r0 = er_cnt;
    good(8'hE0);
    check("R5", ev_cnt - e0, 0);
    good(8'h75);
    expect_ev("R4", e0, r0, 8'h75, 1'b0, 1'b1);
    e0 = ev_cnt;
    good(8'hE0); good(8'hF0);
    check("R5", ev_cnt - e0, 0);
    good(8'h75);
    expect_ev("R4", e0, r0, 8'h75, 1'b1, 1'b1);

    // R5 flags consumed
    e0 = ev_cnt; r0 = er_cnt;
    good(8'h29);
    expect_ev("R5", e0, r0, 8'h29, 1'b0, 1'b0);

    // R6 repeats
    e0 = ev_cnt;
    for (int k = 0; k < 3; k++) good(8'h2B);
    check("R6", ev_cnt - e0, 3);
    check("R6", {last_code, last_rel}, {8'h2B, 1'b0});

    // R7 parity error
    e0 = ev_cnt; r0 = er_cnt;
    send(8'h1C, 1'b1, 1'b0, 1'b0, 11, 1'b0);
    check("R7", ev_cnt - e0, 0);
    check("R7", er_cnt - r0, 1);

    // R8 start and stop errors
    e0 = ev_cnt; r0 = er_cnt;
    send(8'h1C, 1'b0, 1'b1, 1'b0, 11, 1'b0);
    check("R8", er_cnt - r0, 1);
    send(8'h1C, 1'b0, 1'b0, 1'b1, 11, 1'b0);
    check("R8", er_cnt - r0, 2);
    check("R8", ev_cnt - e0, 0);

    // R9 error drops prefix
    good(8'hE0); good(8'hF0);
    r0 = er_cnt;
    send(8'h33, 1'b1, 1'b0, 1'b0, 11, 1'b0);
    check("R9", er_cnt - r0, 1);
    e0 = ev_cnt; r0 = er_cnt;
    good(8'h34);
    expect_ev("R9", e0, r0, 8'h34, 1'b0, 1'b0);

    // R10 timeout
    send(8'h55, 1'b0, 1'b0, 1'b0, 5, 1'b0);
    wait_cyc(2 * TMO);
    e0 = ev_cnt; r0 = er_cnt;
    good(8'h4D);
    expect_ev("R10", e0, r0, 8'h4D, 1'b0, 1'b0);

    // R11 glitch
    e0 = ev_cnt; r0 = er_cnt;
    send(8'h5A, 1'b0, 1'b0, 1'b0, 11, 1'b1);
    expect_ev("R11", e0, r0, 8'h5A, 1'b0, 1'b0);

    // R12 full sweep of non-prefix codes
    for (int v = 0; v < 256; v++) begin
      if (v != 8'hF0 && v != 8'hE0) begin
        e0 = ev_cnt; r0 = er_cnt;
        good(8'(v));
        expect_ev("R12", e0, r0, 8'(v), 1'b0, 1'b0);
      end
    end

    summary();
  end
endmodule